// File: doc/BRIEF.md
# Video capture sync timing tracker

This block sits behind an external video digitiser and runs entirely in the pixel clock that the digitiser recovers. It receives separate horizontal and vertical sync outputs and three colour channels. Each sync first passes through a register synchroniser, then a level qualifier that accepts a new level only after it has been held for consecutive samples. The qualified leading edges drive a horizontal position counter and a vertical line counter.

The two counters define a visible window. Inside that window the block forwards pixels with a valid strobe, a start-of-line marker and a start-of-frame marker. The pixel data passes through a delay line whose length equals the latency of the sync path, so each forwarded pixel is the one sampled at that window position. The board wiring exchanges the red and blue channels, and the block swaps them back.

At every line end and every frame end the block latches the final counter values into debug registers, where a later readout path can read them. Each latched value is compared with the expected total for the mode. A deviation sets a sticky flag, so an unstable sync or pixel clock is visible directly. The defaults describe the 1024x768 at 60 Hz mode with a 65 MHz pixel clock: 1344 clocks per line, 806 lines per frame, and both syncs active low. The active area starts 296 clocks after the horizontal sync leading edge and 35 lines after the vertical sync leading edge.

Top module: `vst_sync_tracker`

## Requirements
- R1: Each sync input passes through SYNC_STAGES register stages (2 by default) in the pixel clock domain. Its qualified level changes only after the synchronised sample has shown the new level for QUAL_LEN consecutive clocks (2 by default). A pulse one clock wide on either sync input has no effect on the counters, the latched values or the pixel stream.
- R2: A parameter per sync selects its polarity (1 = active high, 0 = active low). The leading edge is the transition into the active level.
- R3: The horizontal counter restarts at 0 on each qualified horizontal leading edge and otherwise increments every clock. On that edge its previous value is latched into dbg_line_h, so a line of H_TOTAL clocks latches H_TOTAL-1 (1343 by default).
- R4: The vertical counter increments on each qualified horizontal leading edge and restarts at 0 on a qualified vertical leading edge. The restart wins when the two edges coincide. On the vertical edge the block latches the vertical count into dbg_frame_v and the horizontal count into dbg_frame_h, so a frame of V_TOTAL lines latches V_TOTAL-1 (805 by default).
- R5: vid_valid is high only for pixels whose column is in [H_ACT_START, H_ACT_START+H_ACT_LEN), counted from the horizontal leading edge, and whose line is in [V_ACT_START, V_ACT_START+V_ACT_LEN), counted from the vertical leading edge. It stays low in porches and sync pulses, and until both syncs have shown a leading edge. Every such pixel is forwarded exactly once.
- R6: Each forwarded pixel is the one presented at the input at that window position. vid_r carries pix_b_in, vid_b carries pix_r_in and vid_g carries pix_g_in. All three outputs are zero while vid_valid is low.
- R7: vid_sol is high with the first valid pixel of each line. vid_sof is high only with the first valid pixel of the first active line. Both are low otherwise.
- R8: dbg_line_err becomes 1 when a latched line-end count differs from H_TOTAL-1. The first line end after reset is excluded. The flag holds until err_clr is pulsed.
- R9: dbg_frame_err becomes 1 when a latched frame-end vertical count differs from V_TOTAL-1, or the frame-end horizontal count differs from H_TOTAL-1. The first frame end after reset is excluded. The flag holds until err_clr is pulsed.
- R10: While rst_pix is high, and on the first clock after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock recovered by the digitiser |
| rst_pix | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Horizontal sync from the digitiser |
| vs_in | input | 1 | Vertical sync from the digitiser |
| pix_r_in | input | PIX_W | Channel wired to the red input position (carries blue) |
| pix_g_in | input | PIX_W | Green channel |
| pix_b_in | input | PIX_W | Channel wired to the blue input position (carries red) |
| err_clr | input | 1 | Clears both sticky mismatch flags |
| vid_valid | output | 1 | Pixel inside the visible window |
| vid_sol | output | 1 | First valid pixel of a line |
| vid_sof | output | 1 | First valid pixel of a frame |
| vid_r | output | PIX_W | Red, after the channel swap |
| vid_g | output | PIX_W | Green |
| vid_b | output | PIX_W | Blue, after the channel swap |
| dbg_line_h | output | HCW | Horizontal count latched at the last line end |
| dbg_frame_h | output | HCW | Horizontal count latched at the last frame end |
| dbg_frame_v | output | VCW | Vertical count latched at the last frame end |
| dbg_line_err | output | 1 | Sticky line-length mismatch |
| dbg_frame_err | output | 1 | Sticky frame-length mismatch |

## Verification
A reduced timing of 24 clocks by 10 lines is swept frame by frame. The horizontal sync is active low and the vertical sync active high, so both polarity variants run at once. Every pixel carries its own column and line in its colour values. This exposes any misalignment between the data delay and the sync path, a missing channel swap, or a pixel leaking out of the window. Clean frames set the latched totals and the arming. A frame with one-clock glitches on both syncs shows whether the qualifier rejects them. A shortened line and a frame with one extra line each set exactly one flag, which must stay set until a clear pulse.

// File: rtl/vst_pkg.sv
package vst_pkg;

   // Timing of the 1024x768 at 60 Hz mode, 65 MHz pixel clock
   localparam int XGA_H_TOTAL     = 1344;
   localparam int XGA_V_TOTAL     = 806;
   localparam int XGA_H_ACT_START = 296;   // sync 136 + back porch 160
   localparam int XGA_H_ACT_LEN   = 1024;
   localparam int XGA_V_ACT_START = 35;    // sync 6 + back porch 29
   localparam int XGA_V_ACT_LEN   = 768;

   // Counter width that holds totals up to n with headroom for saturation
   function automatic int cnt_bits(input int n);
      return $clog2(n) + 1;
   endfunction

endpackage

// File: rtl/vst_sync_qual.sv
module vst_sync_qual #(
   parameter int STAGES   = 2,
   parameter int QUAL     = 2,
   parameter bit ACT_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_raw,
   output logic lvl,
   output logic lead
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vst_sync_qual: STAGES must be at least 2");
      end
      if (QUAL < 2) begin : g_bad_qual
         $error("vst_sync_qual: QUAL must be at least 2");
      end
   endgenerate

   logic act_raw;

   // Polarity normalisation: downstream logic sees 1 = active
   generate
      if (ACT_HIGH) begin : g_pos
         assign act_raw = sync_raw;
      end else begin : g_neg
         assign act_raw = ~sync_raw;
      end
   endgenerate

   logic [STAGES-1:0] sync_sr;
   logic [QUAL-1:0]   win;
   logic              smp;
   logic              all_on;
   logic              all_off;

   assign smp    = sync_sr[STAGES-1];
   assign win[0] = smp;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_sr <= '0;
      end else begin
         sync_sr <= {sync_sr[STAGES-2:0], act_raw};
      end
   end

   // Sample history for the level qualifier
   generate
      for (genvar k = 1; k < QUAL; k++) begin : g_hist
         always_ff @(posedge clk) begin
            if (rst) begin
               win[k] <= 1'b0;
            end else begin
               win[k] <= win[k-1];
            end
         end
      end
   endgenerate

   assign all_on  = &win;
   assign all_off = ~|win;

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl  <= 1'b0;
         lead <= 1'b0;
      end else begin
         lead <= all_on & ~lvl;
         if (all_on) begin
            lvl <= 1'b1;
         end else if (all_off) begin
            lvl <= 1'b0;
         end
      end
   end

   // R1
   qual_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lvl != $past(lvl)) |-> ($past(smp) == lvl && $past(smp, 2) == lvl));

endmodule

// File: rtl/vst_pos_counter.sv
module vst_pos_counter #(
   parameter int W      = 12,
   parameter int EXPECT = 1343
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         restart,
   input  logic         extra_bad,
   input  logic         err_clr,
   output logic [W-1:0] cnt,
   output logic [W-1:0] last,
   output logic         err,
   output logic         armed
);

   generate
      if (EXPECT >= (1 << W) - 1) begin : g_bad_w
         $error("vst_pos_counter: W too narrow for EXPECT");
      end
   endgenerate

   localparam logic [W-1:0] CNT_MAX = '1;
   localparam logic [W-1:0] CNT_EXP = W'(EXPECT);

   logic bad;

   assign bad = restart & armed & ((cnt != CNT_EXP) | extra_bad);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         last  <= '0;
         armed <= 1'b0;
      end else if (restart) begin
         cnt   <= '0;
         last  <= cnt;
         armed <= 1'b1;
      end else if (step && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err <= 1'b0;
      end else if (bad) begin
         err <= 1'b1;
      end else if (err_clr) begin
         err <= 1'b0;
      end
   end

   // R3
   restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt == '0));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (err && !err_clr) |=> err);

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (rst)
      (restart && armed && cnt != CNT_EXP) |=> err);

endmodule

// File: rtl/vst_pixel_gate.sv
module vst_pixel_gate #(
   parameter int PW      = 8,
   parameter int HW      = 12,
   parameter int VW      = 11,
   parameter int H_START = 296,
   parameter int H_LEN   = 1024,
   parameter int V_START = 35,
   parameter int V_LEN   = 768,
   parameter int DLY     = 5,
   parameter bit SWAP_RB = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [HW-1:0] hcnt,
   input  logic [VW-1:0] vcnt,
   input  logic [PW-1:0] r_in,
   input  logic [PW-1:0] g_in,
   input  logic [PW-1:0] b_in,
   output logic          valid,
   output logic          sol,
   output logic          sof,
   output logic [PW-1:0] r_out,
   output logic [PW-1:0] g_out,
   output logic [PW-1:0] b_out
);

   localparam int H_END = H_START + H_LEN;
   localparam int V_END = V_START + V_LEN;
   localparam int DW    = 3 * PW;

   generate
      if (DLY < 1) begin : g_bad_dly
         $error("vst_pixel_gate: DLY must be at least 1");
      end
   endgenerate

   // Data delay line matching the sync path latency
   logic [DW-1:0] dl [DLY];

   always_ff @(posedge clk) begin
      if (rst) begin
         dl[0] <= '0;
      end else begin
         dl[0] <= {r_in, g_in, b_in};
      end
   end

   generate
      for (genvar k = 1; k < DLY; k++) begin : g_dly
         always_ff @(posedge clk) begin
            if (rst) begin
               dl[k] <= '0;
            end else begin
               dl[k] <= dl[k-1];
            end
         end
      end
   endgenerate

   logic [PW-1:0] d_r, d_g, d_b;
   logic [PW-1:0] c_r, c_b;

   assign d_r = dl[DLY-1][DW-1 -: PW];
   assign d_g = dl[DLY-1][PW +: PW];
   assign d_b = dl[DLY-1][0 +: PW];

   generate
      if (SWAP_RB) begin : g_swap
         assign c_r = d_b;
         assign c_b = d_r;
      end else begin : g_straight
         assign c_r = d_r;
         assign c_b = d_b;
      end
   endgenerate

   logic in_h, in_v, in_win, at_sol, at_sof;

   assign in_h   = (hcnt >= HW'(H_START)) && (hcnt < HW'(H_END));
   assign in_v   = (vcnt >= VW'(V_START)) && (vcnt < VW'(V_END));
   assign in_win = en & in_h & in_v;
   assign at_sol = in_win & (hcnt == HW'(H_START));
   assign at_sof = at_sol & (vcnt == VW'(V_START));

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         sol   <= 1'b0;
         sof   <= 1'b0;
         r_out <= '0;
         g_out <= '0;
         b_out <= '0;
      end else begin
         valid <= in_win;
         sol   <= at_sol;
         sof   <= at_sof;
         r_out <= in_win ? c_r : '0;
         g_out <= in_win ? d_g : '0;
         b_out <= in_win ? c_b : '0;
      end
   end

   // R7
   sof_in_sol_chk: assert property (@(posedge clk) disable iff (rst)
      sof |-> (sol && valid));

   // R7
   run_starts_sol_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && !$past(valid)) |-> sol);

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(valid) |-> (r_out == '0 && g_out == '0 && b_out == '0));

endmodule

// File: rtl/vst_sync_tracker.sv
module vst_sync_tracker #(
   parameter int  PIX_W       = 8,
   parameter int  H_TOTAL     = vst_pkg::XGA_H_TOTAL,
   parameter int  V_TOTAL     = vst_pkg::XGA_V_TOTAL,
   parameter int  H_ACT_START = vst_pkg::XGA_H_ACT_START,
   parameter int  H_ACT_LEN   = vst_pkg::XGA_H_ACT_LEN,
   parameter int  V_ACT_START = vst_pkg::XGA_V_ACT_START,
   parameter int  V_ACT_LEN   = vst_pkg::XGA_V_ACT_LEN,
   parameter bit  HS_ACT_HIGH = 1'b0,
   parameter bit  VS_ACT_HIGH = 1'b0,
   parameter int  SYNC_STAGES = 2,
   parameter int  QUAL_LEN    = 2,
   parameter bit  SWAP_RB     = 1'b1,
   localparam int HCW         = vst_pkg::cnt_bits(H_TOTAL),
   localparam int VCW         = vst_pkg::cnt_bits(V_TOTAL)
) (
   input  logic             clk_pix,
   input  logic             rst_pix,
   input  logic             hs_in,
   input  logic             vs_in,
   input  logic [PIX_W-1:0] pix_r_in,
   input  logic [PIX_W-1:0] pix_g_in,
   input  logic [PIX_W-1:0] pix_b_in,
   input  logic             err_clr,
   output logic             vid_valid,
   output logic             vid_sol,
   output logic             vid_sof,
   output logic [PIX_W-1:0] vid_r,
   output logic [PIX_W-1:0] vid_g,
   output logic [PIX_W-1:0] vid_b,
   output logic [HCW-1:0]   dbg_line_h,
   output logic [HCW-1:0]   dbg_frame_h,
   output logic [VCW-1:0]   dbg_frame_v,
   output logic             dbg_line_err,
   output logic             dbg_frame_err
);

   // Data latency: sync stages, qualifier window, edge register, counter clear
   localparam int DATA_DLY = SYNC_STAGES + QUAL_LEN + 1;
   localparam logic [HCW-1:0] H_LAST = HCW'(H_TOTAL - 1);

   generate
      if (H_ACT_START + H_ACT_LEN > H_TOTAL) begin : g_bad_hwin
         $error("vst_sync_tracker: horizontal window exceeds line");
      end
      if (V_ACT_START + V_ACT_LEN > V_TOTAL) begin : g_bad_vwin
         $error("vst_sync_tracker: vertical window exceeds frame");
      end
      if (PIX_W < 1) begin : g_bad_pw
         $error("vst_sync_tracker: PIX_W must be positive");
      end
   endgenerate

   logic hs_lvl, hs_lead, vs_lvl, vs_lead;
   logic [HCW-1:0] hcnt;
   logic [VCW-1:0] vcnt;
   logic h_armed, v_armed;

   vst_sync_qual #(
      .STAGES   (SYNC_STAGES),
      .QUAL     (QUAL_LEN),
      .ACT_HIGH (HS_ACT_HIGH)
   ) u_hs_qual (
      .clk      (clk_pix),
      .rst      (rst_pix),
      .sync_raw (hs_in),
      .lvl      (hs_lvl),
      .lead     (hs_lead)
   );

   vst_sync_qual #(
      .STAGES   (SYNC_STAGES),
      .QUAL     (QUAL_LEN),
      .ACT_HIGH (VS_ACT_HIGH)
   ) u_vs_qual (
      .clk      (clk_pix),
      .rst      (rst_pix),
      .sync_raw (vs_in),
      .lvl      (vs_lvl),
      .lead     (vs_lead)
   );

   vst_pos_counter #(
      .W      (HCW),
      .EXPECT (H_TOTAL - 1)
   ) u_hcnt (
      .clk       (clk_pix),
      .rst       (rst_pix),
      .step      (1'b1),
      .restart   (hs_lead),
      .extra_bad (1'b0),
      .err_clr   (err_clr),
      .cnt       (hcnt),
      .last      (dbg_line_h),
      .err       (dbg_line_err),
      .armed     (h_armed)
   );

   vst_pos_counter #(
      .W      (VCW),
      .EXPECT (V_TOTAL - 1)
   ) u_vcnt (
      .clk       (clk_pix),
      .rst       (rst_pix),
      .step      (hs_lead),
      .restart   (vs_lead),
      .extra_bad (hcnt != H_LAST),
      .err_clr   (err_clr),
      .cnt       (vcnt),
      .last      (dbg_frame_v),
      .err       (dbg_frame_err),
      .armed     (v_armed)
   );

   // Horizontal position at frame end
   always_ff @(posedge clk_pix) begin
      if (rst_pix) begin
         dbg_frame_h <= '0;
      end else if (vs_lead) begin
         dbg_frame_h <= hcnt;
      end
   end

   vst_pixel_gate #(
      .PW      (PIX_W),
      .HW      (HCW),
      .VW      (VCW),
      .H_START (H_ACT_START),
      .H_LEN   (H_ACT_LEN),
      .V_START (V_ACT_START),
      .V_LEN   (V_ACT_LEN),
      .DLY     (DATA_DLY),
      .SWAP_RB (SWAP_RB)
   ) u_gate (
      .clk   (clk_pix),
      .rst   (rst_pix),
      .en    (h_armed & v_armed),
      .hcnt  (hcnt),
      .vcnt  (vcnt),
      .r_in  (pix_r_in),
      .g_in  (pix_g_in),
      .b_in  (pix_b_in),
      .valid (vid_valid),
      .sol   (vid_sol),
      .sof   (vid_sof),
      .r_out (vid_r),
      .g_out (vid_g),
      .b_out (vid_b)
   );

   // R8
   line_err_src_chk: assert property (@(posedge clk_pix) disable iff (rst_pix)
      $rose(dbg_line_err) |-> $past(hs_lead));

   // R9
   frame_err_src_chk: assert property (@(posedge clk_pix) disable iff (rst_pix)
      $rose(dbg_frame_err) |-> $past(vs_lead));

   // R4
   frame_latch_stable_chk: assert property (@(posedge clk_pix) disable iff (rst_pix)
      !$past(vs_lead) |-> ($stable(dbg_frame_v) && $stable(dbg_frame_h)));

   // R5
   valid_needs_sync_chk: assert property (@(posedge clk_pix) disable iff (rst_pix)
      vid_valid |-> (h_armed && v_armed));

   // R1
   lead_level_chk: assert property (@(posedge clk_pix) disable iff (rst_pix)
      (hs_lead || vs_lead) |-> (hs_lead ? hs_lvl : 1'b1) && (vs_lead ? vs_lvl : 1'b1));

endmodule

// File: tb/vst_sync_tracker_tb.sv
module vst_sync_tracker_tb;

   localparam int PW  = 8;
   localparam int HT  = 24;
   localparam int VT  = 10;
   localparam int HAS = 6;
   localparam int HAL = 12;
   localparam int VAS = 3;
   localparam int VAL = 5;
   localparam int HCW = $clog2(HT) + 1;
   localparam int VCW = $clog2(VT) + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hs_in = 1'b1;      // active low
   logic vs_in = 1'b0;      // active high
   logic [PW-1:0] pr = '0, pg = '0, pb = '0;
   logic err_clr = 1'b0;
   logic vid_valid, vid_sol, vid_sof;
   logic [PW-1:0] vid_r, vid_g, vid_b;
   logic [HCW-1:0] dbg_line_h, dbg_frame_h;
   logic [VCW-1:0] dbg_frame_v;
   logic dbg_line_err, dbg_frame_err;

   int n_chk = 0;
   int n_fail = 0;
   bit run = 1'b0;
   int exp_q[$];

   always #4 clk = ~clk;

   vst_sync_tracker #(
      .PIX_W(PW), .H_TOTAL(HT), .V_TOTAL(VT),
      .H_ACT_START(HAS), .H_ACT_LEN(HAL),
      .V_ACT_START(VAS), .V_ACT_LEN(VAL),
      .HS_ACT_HIGH(1'b0), .VS_ACT_HIGH(1'b1)
   ) u_dut (
      .clk_pix(clk), .rst_pix(rst), .hs_in(hs_in), .vs_in(vs_in),
      .pix_r_in(pr), .pix_g_in(pg), .pix_b_in(pb), .err_clr(err_clr),
      .vid_valid(vid_valid), .vid_sol(vid_sol), .vid_sof(vid_sof),
      .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
      .dbg_line_h(dbg_line_h), .dbg_frame_h(dbg_frame_h),
      .dbg_frame_v(dbg_frame_v), .dbg_line_err(dbg_line_err),
      .dbg_frame_err(dbg_frame_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Output stream monitor, sampled after the active edge
   always @(posedge clk) begin
      #2;
      if (run) begin
         if (vid_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 valid outside window", 1, 0);
            end else begin
               int e, ex, eg;
               e  = exp_q.pop_front();
               ex = e >> 8;
               eg = e & 255;
               chk(int'(vid_b) == ex, "R6 blue from red position", int'(vid_b), ex);
               chk(int'(vid_r) == (ex ^ 8'hA5), "R6 red from blue position", int'(vid_r), ex ^ 8'hA5);
               chk(int'(vid_g) == eg, "R6 green line tag", int'(vid_g), eg);
               chk(vid_sol == (ex == HAS), "R7 start of line", int'(vid_sol), int'(ex == HAS));
               chk(vid_sof == (ex == HAS && (eg & 15) == VAS), "R7 start of frame",
                   int'(vid_sof), int'(ex == HAS && (eg & 15) == VAS));
            end
         end else begin
            chk(vid_r == '0 && vid_g == '0 && vid_b == '0 && !vid_sol && !vid_sof,
                "R6 outputs zero outside window", int'(vid_r) + int'(vid_g) + int'(vid_b), 0);
         end
      end
   end

   initial begin
      #(8 * 200000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R10
      chk(!vid_valid && !vid_sol && !vid_sof, "R10 reset strobes", int'(vid_valid), 0);
      chk(dbg_line_h == '0 && dbg_frame_h == '0 && dbg_frame_v == '0, "R10 reset latches",
          int'(dbg_line_h) + int'(dbg_frame_v), 0);
      chk(!dbg_line_err && !dbg_frame_err, "R10 reset flags", int'(dbg_line_err), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(!vid_valid && !dbg_line_err && !dbg_frame_err && dbg_line_h == '0,
          "R10 first clock after reset", int'(vid_valid), 0);
      run = 1'b1;
      for (int f = 0; f < 6; f++) begin
         int nl;
         nl = (f == 4) ? VT + 1 : VT;
         for (int y = 0; y < nl; y++) begin
            int ll;
            ll = (f == 3 && y == 6) ? HT - 4 : HT;
            for (int x = 0; x < ll; x++) begin
               @(negedge clk);
               // R2: horizontal sync active low for 3 clocks, vertical active high for 2 lines
               hs_in = (x < 3) ? 1'b0 : 1'b1;
               vs_in = (y < 2) ? 1'b1 : 1'b0;
               // R1: one-clock glitches in frame 2
               if (f == 2 && y == 4 && x == 12) hs_in = 1'b0;
               if (f == 2 && y == 5 && x == 3)  vs_in = 1'b1;
               pr = PW'(x);
               pg = PW'((f << 4) | y);
               pb = PW'(x ^ 8'hA5);
               err_clr = ((f == 4 || f == 5) && y == 2 && x == 0);
               if (x >= HAS && x < HAS + HAL && y >= VAS && y < VAS + VAL)
                  exp_q.push_back((x << 8) | ((f << 4) | y));
               if (x == 12) begin
                  if ((f == 1 || f == 3) && y == 1) begin
                     // R3 R4 R2 and, in frame 3, R1 after the glitches
                     chk(int'(dbg_line_h) == HT - 1, "R3 line end count", int'(dbg_line_h), HT - 1);
                     chk(int'(dbg_frame_v) == VT - 1, "R4 frame end lines", int'(dbg_frame_v), VT - 1);
                     chk(int'(dbg_frame_h) == HT - 1, "R4 frame end column", int'(dbg_frame_h), HT - 1);
                     chk(!dbg_line_err, "R8 R1 no line error", int'(dbg_line_err), 0);
                     chk(!dbg_frame_err, "R9 R1 no frame error", int'(dbg_frame_err), 0);
                  end
                  if (f == 3 && y == 7) begin
                     chk(int'(dbg_line_h) == HT - 5, "R3 short line count", int'(dbg_line_h), HT - 5);
                     chk(dbg_line_err, "R8 short line flagged", int'(dbg_line_err), 1);
                  end
                  if (f == 3 && y == 8) begin
                     chk(int'(dbg_line_h) == HT - 1, "R3 line count recovers", int'(dbg_line_h), HT - 1);
                     chk(dbg_line_err, "R8 flag sticky", int'(dbg_line_err), 1);
                  end
                  if (f == 4 && y == 1) begin
                     chk(!dbg_frame_err, "R9 short line keeps frame ok", int'(dbg_frame_err), 0);
                     chk(dbg_line_err, "R8 flag held across frame", int'(dbg_line_err), 1);
                  end
                  if (f == 4 && y == 3)
                     chk(!dbg_line_err, "R8 clear", int'(dbg_line_err), 0);
                  if (f == 5 && y == 1) begin
                     chk(int'(dbg_frame_v) == VT, "R4 long frame count", int'(dbg_frame_v), VT);
                     chk(dbg_frame_err, "R9 long frame flagged", int'(dbg_frame_err), 1);
                     chk(!dbg_line_err, "R8 long frame lines ok", int'(dbg_line_err), 0);
                  end
                  if (f == 5 && y == 3)
                     chk(!dbg_frame_err, "R9 clear", int'(dbg_frame_err), 0);
               end
            end
         end
      end
      hs_in = 1'b1;
      vs_in = 1'b0;
      err_clr = 1'b0;
      repeat (40) @(negedge clk);
      // R5: every window pixel forwarded exactly once
      chk(exp_q.size() == 0, "R5 window pixels all forwarded", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule